// File: doc/BRIEF.md
# Compare-Value Physical Timer

This block holds a 64-bit compare value and checks it against a free-running system count supplied from outside. While the timer is enabled, it raises a level-sensitive condition flag once the count has reached or passed the compare value. Software loads the compare value in a single transfer of two 32-bit words, one for the upper half and one for the lower half. Both halves land on the same clock edge, so the comparison never sees a half-updated value.

The counter feeding the block may be narrower than 64 bits, and a width input gives its size. Compare bits at or above that width are not stored and read back as zero. Count bits at or above that width take no part in the comparison. The compare value counts as zero-extended in every test. The flag is registered, so it follows a change of count, compare value or enable one clock edge later. After reset the compare value is all ones at the configured width and the flag is low, so the condition stays false until software programs a value.

Top module: `phys_cmp_timer`

## Requirements
- R1: While `rst` is high, and after reset until the first write, `cval_rdata` equals all ones at the configured width and `tmr_cond` is 0.
- R2: A cycle with `cval_wr` high loads `{cval_wdata_hi, cval_wdata_lo}` as one value on that edge. The high word forms bits [63:32] and the low word bits [31:0]. `cval_rdata` shows the value after that edge.
- R3: After an edge where `tmr_enable` was 1, `tmr_cond` is 1 exactly when, before that edge, the count masked to the width was greater than or equal to the stored compare value, taken as unsigned.
- R4: After an edge where `tmr_enable` was 0, `tmr_cond` is 0, whatever the count and compare value are.
- R5: With `cnt_bits` = N, where N is from 1 to 63, bits [63:N] of `cval_rdata` are 0, and written data in those bits is dropped.
- R6: Count bits at or above the configured width have no effect on `tmr_cond`.
- R7: Without a write and with `cnt_bits` unchanged, `cval_rdata` holds its value.
- R8: A count equal to the compare value sets the condition, and a count one below it does not. This includes a compare value of 0 and the all-ones value.
- R9: A `cnt_bits` value of 0 or of 64 and above selects the full 64-bit width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_count | input | 64 | Free-running system count |
| tmr_enable | input | 1 | Timer enable; 0 forces the condition low |
| cval_wr | input | 1 | Write strobe for the compare value |
| cval_wdata_lo | input | 32 | Compare value bits [31:0] |
| cval_wdata_hi | input | 32 | Compare value bits [63:32] |
| cnt_bits | input | 7 | Implemented counter width; 0 or 64 and above means 64 |
| cval_rdata | output | 64 | Compare value readback, zero above the width |
| tmr_cond | output | 1 | Registered timer condition |

## Verification
The bound checker tests on every cycle that:
- a disabled timer gives a low flag on the next edge;
- the flag follows the masked count-versus-compare relation one edge later;
- readback carries no bits above the width;
- a write appears whole on readback;
- readback is stable without a write.

The equality and off-by-one boundaries, the reset value and the treatment of out-of-range widths are shown by the bench's directed scenarios. The same holds for the wrap cases at zero and at all ones, and for the random mix of widths and counts placed close to the compare value.

// File: rtl/pct_pkg.sv
package pct_pkg;

    localparam int CVAL_W = 64;
    localparam int HALF_W = CVAL_W / 2;
    localparam int WID_W  = $clog2(CVAL_W) + 1;

    typedef logic [CVAL_W-1:0] cval_t;
    typedef logic [WID_W-1:0]  width_t;

    typedef struct packed {
        logic              vld;
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } cval_wr_t;

    typedef struct packed {
        logic  borrow;
        cval_t diff;
    } cmp_diff_t;

    function automatic logic width_is_full(input width_t w);
        return (w == '0) || (int'(w) >= CVAL_W);
    endfunction

    function automatic cval_t join_halves(input cval_wr_t req);
        return {req.hi, req.lo};
    endfunction

    function automatic cmp_diff_t sub_ext(input cval_t a, input cval_t b);
        logic [CVAL_W:0] d;
        d = {1'b0, a} - {1'b0, b};
        return '{borrow: d[CVAL_W], diff: d[CVAL_W-1:0]};
    endfunction

endpackage

// File: rtl/pct_width_mask.sv
module pct_width_mask
    import pct_pkg::*;
#(
    parameter int W  = CVAL_W,
    parameter int WW = WID_W
) (
    input  logic [WW-1:0] cnt_bits,
    output logic [W-1:0]  mask
);
    logic full;
    assign full = width_is_full(width_t'(cnt_bits));

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [WW-1:0] IDX = WW'(i);
        assign mask[i] = full | (cnt_bits > IDX);
    end
endmodule

// File: rtl/pct_cval_reg.sv
module pct_cval_reg
    import pct_pkg::*;
#(
    parameter int W = CVAL_W
) (
    input  logic     clk,
    input  logic     rst,
    input  cval_wr_t wr,
    input  logic [W-1:0] mask,
    output logic [W-1:0] cval
);
    logic [W-1:0] cval_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cval_q <= '1;
        end else if (wr.vld) begin
            cval_q <= join_halves(wr) & mask;
        end
    end

    assign cval = cval_q & mask;
endmodule

// File: rtl/pct_cond_eval.sv
module pct_cond_eval
    import pct_pkg::*;
#(
    parameter int W = CVAL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cval,
    input  logic [W-1:0] mask,
    output logic         cond
);
    cmp_diff_t d;
    logic      ge;
    logic      cond_q;

    always_comb begin
        d  = sub_ext(count & mask, cval);
        ge = ~d.borrow;
    end

    always_ff @(posedge clk) begin
        if (rst) cond_q <= 1'b0;
        else     cond_q <= enable & ge;
    end

    assign cond = cond_q;
endmodule

// File: rtl/phys_cmp_timer.sv
module phys_cmp_timer
    import pct_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CVAL_W-1:0] sys_count,
    input  logic              tmr_enable,
    input  logic              cval_wr,
    input  logic [HALF_W-1:0] cval_wdata_lo,
    input  logic [HALF_W-1:0] cval_wdata_hi,
    input  logic [WID_W-1:0]  cnt_bits,
    output logic [CVAL_W-1:0] cval_rdata,
    output logic              tmr_cond
);
    logic [CVAL_W-1:0] mask;
    logic [CVAL_W-1:0] cval;
    cval_wr_t          wr;

    assign wr = '{vld: cval_wr, hi: cval_wdata_hi, lo: cval_wdata_lo};

    pct_width_mask #(.W(CVAL_W), .WW(WID_W)) u_mask (
        .cnt_bits (cnt_bits),
        .mask     (mask)
    );

    pct_cval_reg #(.W(CVAL_W)) u_reg (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .mask (mask),
        .cval (cval)
    );

    pct_cond_eval #(.W(CVAL_W)) u_cond (
        .clk    (clk),
        .rst    (rst),
        .enable (tmr_enable),
        .count  (sys_count),
        .cval   (cval),
        .mask   (mask),
        .cond   (tmr_cond)
    );

    assign cval_rdata = cval;
endmodule

// File: rtl/phys_cmp_timer_chk.sv
module phys_cmp_timer_chk
    import pct_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CVAL_W-1:0] sys_count,
    input logic              tmr_enable,
    input logic              cval_wr,
    input logic [HALF_W-1:0] cval_wdata_lo,
    input logic [HALF_W-1:0] cval_wdata_hi,
    input logic [WID_W-1:0]  cnt_bits,
    input logic [CVAL_W-1:0] cval_rdata,
    input logic              tmr_cond
);
    function automatic cval_t chk_mask(input width_t w);
        cval_t m;
        for (int i = 0; i < CVAL_W; i++) m[i] = width_is_full(w) || (int'(w) > i);
        return m;
    endfunction

    // R4: disabled timer gives a low flag on the next edge
    a_r4_disabled_low: assert property (@(posedge clk) disable iff (rst)
        !tmr_enable |=> !tmr_cond);

    // R3: flag follows the masked count-versus-compare relation
    a_r3_cond_tracks: assert property (@(posedge clk) disable iff (rst)
        tmr_enable |=> (tmr_cond == ($past(sys_count & chk_mask(cnt_bits)) >= $past(cval_rdata))));

    // R5: no readback bits above the configured width
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (cval_rdata & ~chk_mask(cnt_bits)) == '0);

    // R2: a write lands whole
    a_r2_atomic_write: assert property (@(posedge clk) disable iff (rst)
        cval_wr |=> (!$stable(cnt_bits) ||
                     cval_rdata == ($past({cval_wdata_hi, cval_wdata_lo}) & chk_mask(cnt_bits))));

    // R7: value held without a write
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !cval_wr |=> (!$stable(cnt_bits) || $stable(cval_rdata)));
endmodule

bind phys_cmp_timer phys_cmp_timer_chk u_chk (.*);

// File: tb/phys_cmp_timer_tb.sv
module phys_cmp_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] sys_count;
    logic        tmr_enable;
    logic        cval_wr;
    logic [31:0] cval_wdata_lo;
    logic [31:0] cval_wdata_hi;
    logic [6:0]  cnt_bits;
    logic [63:0] cval_rdata;
    logic        tmr_cond;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic [63:0] m_cmp;
    logic        m_cond;

    always #(CLK_PERIOD/2) clk = ~clk;

    phys_cmp_timer u_dut (.*);

    function automatic logic [63:0] f_mask(input logic [6:0] w);
        if (w == 0 || w >= 64) return '1;
        return (64'd1 << w) - 64'd1;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, model the edge, check at the following negedge
    task automatic cyc(input string req, input logic en, input logic [63:0] cnt,
                       input logic wr, input logic [31:0] hi, input logic [31:0] lo,
                       input logic [6:0] w);
        logic [63:0] m;
        tmr_enable = en; sys_count = cnt; cval_wr = wr;
        cval_wdata_hi = hi; cval_wdata_lo = lo; cnt_bits = w;
        m = f_mask(w);
        m_cond = en && ((cnt & m) >= (m_cmp & m));
        if (wr) m_cmp = {hi, lo} & m;
        @(posedge clk);
        @(negedge clk);
        check({req, " rdata"}, cval_rdata, m_cmp & m);
        check({req, " cond"}, {63'd0, tmr_cond}, {63'd0, m_cond});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] base;
        logic [6:0]  w;
        void'($urandom(32'd1234));
        rst = 1; tmr_enable = 0; sys_count = 0; cval_wr = 0;
        cval_wdata_hi = 0; cval_wdata_lo = 0; cnt_bits = 7'd64;
        m_cmp = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset rdata", cval_rdata, '1);
        check("R1 reset cond", {63'd0, tmr_cond}, 64'd0);
        rst = 0;
        // R1: all-ones stays; big count below all-ones -> no condition
        cyc("R1", 1, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, 0, 7'd64);
        cyc("R1", 1, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, 0, 7'd64);
        // R2: atomic write, half order
        cyc("R2", 0, 0, 1, 32'h1234_5678, 32'h9ABC_DEF0, 7'd64);
        check("R2 order", cval_rdata, 64'h1234_5678_9ABC_DEF0);
        // R8 boundary: equal and one below
        cyc("R8", 1, 64'h1234_5678_9ABC_DEEF, 0, 0, 0, 7'd64);
        cyc("R8", 1, 64'h1234_5678_9ABC_DEF0, 0, 0, 0, 7'd64);
        cyc("R3", 1, 64'hFFFF_0000_0000_0000, 0, 0, 0, 7'd64);
        // R4: disable forces low
        cyc("R4", 0, 64'hFFFF_0000_0000_0000, 0, 0, 0, 7'd64);
        check("R4 low", {63'd0, tmr_cond}, 64'd0);
        // R8: compare zero always met; all ones only at max count
        cyc("R8", 1, 64'd5, 1, 0, 0, 7'd64);
        cyc("R8", 1, 64'd0, 0, 0, 0, 7'd64);
        cyc("R8", 1, 64'd0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 7'd64);
        cyc("R8", 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 7'd64);
        // R5: narrow width drops upper write bits
        cyc("R5", 0, 0, 1, 32'hDEAD_BEEF, 32'h0000_1000, 7'd40);
        check("R5 upper", cval_rdata, 64'h0000_00EF_0000_1000);
        // R6: count bits above width ignored
        cyc("R6", 1, 64'hFFFF_FF00_0000_0FFF, 0, 0, 0, 7'd40);
        cyc("R6", 1, 64'hFFFF_FF00_0000_0FFF, 0, 0, 0, 7'd40);
        check("R6 ignored", {63'd0, tmr_cond}, 64'd0);
        // R7: hold with no write
        cyc("R7", 1, 64'd0, 0, 32'h5555_5555, 32'h5555_5555, 7'd40);
        // R9: width 0 and width 100 act as full width
        cyc("R9", 0, 0, 1, 32'hA000_0000, 32'h1, 7'd0);
        check("R9 zero width", cval_rdata, 64'hA000_0000_0000_0001);
        cyc("R9", 1, 64'hA000_0000_0000_0000, 0, 0, 0, 7'd100);
        cyc("R9", 1, 64'hA000_0000_0000_0001, 0, 0, 0, 7'd100);
        // random mix near the compare value
        for (int k = 0; k < 400; k++) begin
            case ($urandom % 4)
                0: w = 7'd64;
                1: w = 7'd32;
                2: w = 7'($urandom % 63 + 1);
                default: w = 7'($urandom % 128);
            endcase
            if (($urandom % 5) == 0)
                cyc("R2", $urandom % 2 == 0, {$urandom, $urandom}, 1, $urandom, $urandom, w);
            else begin
                base = m_cmp + 64'(signed'(32'($urandom % 7)) - 3);
                cyc("R3", ($urandom % 4) != 0, base, 0, $urandom, $urandom, w);
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule